// File: doc/BRIEF.md
# 1-Wire Slot Sequencer with Release-Time Capture

This block drives an open-drain 1-Wire bus. The host first loads a list of slot kinds into a small memory: write-1, write-0 or read. It then sets a slot count and pulses a transfer strobe. The engine divides the system clock down to a 1 µs tick and plays the slots in address order. Each slot is 80 µs long. While it runs, the engine watches the synchronized bus line and stores, for every slot, the number of microseconds from the start of the slot to the first time the line goes high again. The host reads those times back through a separate port, together with a derived bit. Bytes go out least-significant bit first, so the host loads bit 0 of a byte at the lowest slot address.

A separate strobe sends a reset pulse of 500 µs inside a 1000 µs window. During that window the engine records the time of the last rising edge on the bus. A rise at 600 µs or later means a device stretched the low period with its presence pulse. An earlier rise, or no rise at all, means no device is present. A done flag reports the end of either operation.

Top module: `ow_slot_engine`

## Requirements
- R1: The engine's time base is one tick every CLK_DIV clocks (1 µs), and each data slot lasts SLOT_US = 80 µs. A transfer of N slots raises done_o exactly N·80·CLK_DIV + 1 clocks after the clock edge that accepts the strobe.
- R2: Kind code 0 is write-0 and holds bus_oe_o for 70 µs. Kind code 1 is write-1 and holds it for 10 µs. Codes 2 and 3 are read slots and hold it for 10 µs. For the rest of the slot the bus is released. Slots run from address 0 upward.
- R3: For each slot, rd_time_o holds the µs count from the start of the slot to the first rising edge of the synchronized bus. rd_bit_o is 1 exactly when that count is greater than 15.
- R4: A slot in which the bus never rises stores the value 80.
- R5: A reset holds bus_oe_o for 500 µs inside a 1000 µs window, and raises done_o 1000·CLK_DIV + 1 clocks after it is accepted.
- R6: After a reset, presence_o is 1 when the last bus rise in the window came at 600 µs or later. It is 0 when the rise came earlier or when there was no rise.
- R7: A count above 128 runs exactly 128 slots. A count of 0 raises done_o one clock after it is accepted.
- R8: done_o is 0 after reset. It clears on the edge that accepts a start, rises one clock after the operation ends, and then holds until the next accepted start.
- R9: A start strobe that arrives while an operation runs is ignored. When both strobes arrive together in idle, the reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write enable for the slot-kind memory |
| wr_addr_i | input | IDX_W | Slot address to write |
| wr_kind_i | input | 2 | Slot kind: 0 write-0, 1 write-1, 2/3 read |
| count_i | input | CNT_W | Number of slots for the next transfer |
| start_rst_i | input | 1 | Start a reset/presence window |
| start_xfer_i | input | 1 | Start a slot transfer |
| rd_addr_i | input | IDX_W | Result read address |
| rd_time_o | output | TW | Captured release time of the addressed slot, in µs |
| rd_bit_o | output | 1 | Read bit derived from rd_time_o |
| done_o | output | 1 | Operation finished |
| presence_o | output | 1 | A device answered the last reset |
| bus_oe_o | output | 1 | 1 pulls the bus low |
| bus_i | input | 1 | Bus level as seen at the pin |

## Verification
The main stimulus is a transfer that mixes all four kind codes with a modelled device that stretches the low time by different amounts. The holds are chosen to land below the slot's own low time, exactly at the read threshold, one microsecond above it, right up against the end of the slot, and across the end of the slot. Together these separate the write-0 and write-1 lengths, whether the first or the last rise is taken, the strict threshold comparison, and the fallback value for a slot with no rise. The reset windows use holds of 0, 599, 600 and 620 µs, which pin down the edge of the presence decision. Done timing is measured in clocks for full, empty and over-long counts, and with a second strobe issued while the engine is busy.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    K_W0  = 2'd0,
    K_W1  = 2'd1,
    K_RD  = 2'd2,
    K_RDX = 2'd3
  } ow_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RST  = 2'd1,
    ST_XFER = 2'd2,
    ST_FIN  = 2'd3
  } ow_state_e;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int CLK_DIV = 72
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(CLK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clr_i || tick_o) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == DIV_END) && !clr_i;

  // R1: a tick never repeats on consecutive clocks
  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ow_bus_sync.sv
module ow_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic rise_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '1;
    else         s_q <= {s_q[1:0], bus_i};
  end

  assign rise_o = s_q[1] & ~s_q[2];

  // R3: a rise is a single-cycle event
  a_r3_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ow_slot_store.sv
module ow_slot_store #(
  parameter int MAX_SLOTS = 128,
  parameter int SLOT_US   = 80
) (
  input  logic                          clk_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(MAX_SLOTS)-1:0]  wr_addr_i,
  input  logic [1:0]                    wr_kind_i,
  input  logic [$clog2(MAX_SLOTS)-1:0]  kind_idx_i,
  output logic [1:0]                    kind_o,
  input  logic                          cap_we_i,
  input  logic [$clog2(MAX_SLOTS)-1:0]  cap_idx_i,
  input  logic [$clog2(SLOT_US+1)-1:0]  cap_val_i,
  input  logic [$clog2(MAX_SLOTS)-1:0]  rd_addr_i,
  output logic [$clog2(SLOT_US+1)-1:0]  rd_time_o
);
  localparam int TW = $clog2(SLOT_US + 1);

  logic [1:0]    kind_mem [MAX_SLOTS];
  logic [TW-1:0] time_mem [MAX_SLOTS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) kind_mem[wr_addr_i] <= wr_kind_i;
  end

  always_ff @(posedge clk_i) begin
    if (cap_we_i) time_mem[cap_idx_i] <= cap_val_i;
  end

  assign kind_o    = kind_mem[kind_idx_i];
  assign rd_time_o = time_mem[rd_addr_i];
endmodule

// File: rtl/ow_seq.sv
module ow_seq
  import ow_pkg::*;
#(
  parameter int MAX_SLOTS   = 128,
  parameter int SLOT_US     = 80,
  parameter int W1_LOW_US   = 10,
  parameter int W0_LOW_US   = 70,
  parameter int RD_LOW_US   = 10,
  parameter int RST_LOW_US  = 500,
  parameter int RST_WIN_US  = 1000,
  parameter int PRES_MIN_US = 600
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 tick_i,
  input  logic                                 rise_i,
  input  logic                                 start_rst_i,
  input  logic                                 start_xfer_i,
  input  logic [$clog2(MAX_SLOTS+1)-1:0]       count_i,
  input  logic [1:0]                           kind_i,
  output logic [$clog2(MAX_SLOTS)-1:0]         kind_idx_o,
  output logic                                 cap_we_o,
  output logic [$clog2(MAX_SLOTS)-1:0]         cap_idx_o,
  output logic [$clog2(SLOT_US+1)-1:0]         cap_val_o,
  output logic                                 clr_o,
  output logic                                 bus_oe_o,
  output logic                                 done_o,
  output logic                                 presence_o
);
  localparam int IDX_W = $clog2(MAX_SLOTS);
  localparam int CNT_W = $clog2(MAX_SLOTS + 1);
  localparam int TW    = $clog2(SLOT_US + 1);
  localparam int UW    = $clog2((RST_WIN_US > SLOT_US) ? RST_WIN_US : SLOT_US);

  localparam logic [UW-1:0]    SLOT_END = UW'(SLOT_US - 1);
  localparam logic [UW-1:0]    WIN_END  = UW'(RST_WIN_US - 1);
  localparam logic [UW-1:0]    RST_LOW  = UW'(RST_LOW_US);
  localparam logic [UW-1:0]    PRES_MIN = UW'(PRES_MIN_US);
  localparam logic [UW-1:0]    W1_LOW   = UW'(W1_LOW_US);
  localparam logic [UW-1:0]    W0_LOW   = UW'(W0_LOW_US);
  localparam logic [UW-1:0]    RD_LOW   = UW'(RD_LOW_US);
  localparam logic [TW-1:0]    NO_RISE  = TW'(SLOT_US);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_SLOTS);

  ow_state_e        state_q;
  logic [UW-1:0]    us_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             cap_seen_q, mode_rst_q;
  logic [UW-1:0]    rst_time_q;
  logic             done_q, pres_q;

  logic             idle, acc_rst, acc_xfer;
  logic [CNT_W-1:0] n_eff;
  logic [UW-1:0]    low_len;
  logic             first_rise, slot_end;

  assign idle     = (state_q == ST_IDLE);
  assign acc_rst  = idle && start_rst_i;
  assign acc_xfer = idle && start_xfer_i && !start_rst_i;
  assign clr_o    = acc_rst || acc_xfer;
  assign n_eff    = (count_i > CNT_MAX) ? CNT_MAX : count_i;

  always_comb begin
    case (kind_i)
      K_W0:    low_len = W0_LOW;
      K_W1:    low_len = W1_LOW;
      default: low_len = RD_LOW;
    endcase
  end

  assign first_rise = (state_q == ST_XFER) && rise_i && !cap_seen_q;
  assign slot_end   = (state_q == ST_XFER) && tick_i && (us_q == SLOT_END);

  assign cap_we_o   = first_rise || (slot_end && !cap_seen_q);
  assign cap_val_o  = first_rise ? us_q[TW-1:0] : NO_RISE;
  assign cap_idx_o  = idx_q;
  assign kind_idx_o = idx_q;

  always_comb begin
    case (state_q)
      ST_RST:  bus_oe_o = (us_q < RST_LOW);
      ST_XFER: bus_oe_o = (us_q < low_len);
      default: bus_oe_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      us_q       <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      cap_seen_q <= 1'b0;
      mode_rst_q <= 1'b0;
      rst_time_q <= '0;
      done_q     <= 1'b0;
      pres_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (acc_rst) begin
            state_q    <= ST_RST;
            us_q       <= '0;
            rst_time_q <= '0;
            mode_rst_q <= 1'b1;
            done_q     <= 1'b0;
          end else if (acc_xfer) begin
            state_q    <= (n_eff == '0) ? ST_FIN : ST_XFER;
            us_q       <= '0;
            idx_q      <= '0;
            last_q     <= IDX_W'(n_eff - 1'b1);
            cap_seen_q <= 1'b0;
            mode_rst_q <= 1'b0;
            done_q     <= 1'b0;
          end
        end
        ST_RST: begin
          if (rise_i) rst_time_q <= us_q;  // last rise wins
          if (tick_i) begin
            if (us_q == WIN_END) state_q <= ST_FIN;
            else                 us_q    <= us_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (first_rise) cap_seen_q <= 1'b1;
          if (tick_i) begin
            if (us_q == SLOT_END) begin
              cap_seen_q <= 1'b0;
              us_q       <= '0;
              if (idx_q == last_q) state_q <= ST_FIN;
              else                 idx_q   <= idx_q + 1'b1;
            end else begin
              us_q <= us_q + 1'b1;
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (mode_rst_q) pres_q <= (rst_time_q >= PRES_MIN);
        end
      endcase
    end
  end

  assign done_o     = done_q;
  assign presence_o = pres_q;

  // R8: done holds until a start strobe
  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_rst_i && !start_xfer_i) |=> done_q);

  // R9: a reset strobe during a transfer does not start a reset
  a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && start_rst_i) |=> (state_q != ST_RST));

  // R1: slot boundary advances to the next slot with a fresh timer
  a_r1_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end && idx_q != last_q) |=> (us_q == '0 && idx_q == $past(idx_q) + 1'b1));

  // R4: stored times never exceed the slot length
  a_r4_cap_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we_o |-> (cap_val_o <= NO_RISE));

  // R2: bus is released while done is shown
  a_r2_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !bus_oe_o);
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter int CLK_DIV      = 72,
  parameter int MAX_SLOTS    = 128,
  parameter int SLOT_US      = 80,
  parameter int W1_LOW_US    = 10,
  parameter int W0_LOW_US    = 70,
  parameter int RD_LOW_US    = 10,
  parameter int RST_LOW_US   = 500,
  parameter int RST_WIN_US   = 1000,
  parameter int PRES_MIN_US  = 600,
  parameter int RD_ONE_GT_US = 15,
  localparam int IDX_W = $clog2(MAX_SLOTS),
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int TW    = $clog2(SLOT_US + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [1:0]       wr_kind_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             start_rst_i,
  input  logic             start_xfer_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [TW-1:0]    rd_time_o,
  output logic             rd_bit_o,
  output logic             done_o,
  output logic             presence_o,
  output logic             bus_oe_o,
  input  logic             bus_i
);
  localparam logic [TW-1:0] RD_ONE_GT = TW'(RD_ONE_GT_US);

  logic             tick, rise, clr;
  logic [IDX_W-1:0] kind_idx, cap_idx;
  logic [1:0]       kind;
  logic             cap_we;
  logic [TW-1:0]    cap_val;

  ow_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(clr), .tick_o(tick)
  );

  ow_bus_sync u_sync (
    .clk_i, .rst_ni, .bus_i, .rise_o(rise)
  );

  ow_slot_store #(.MAX_SLOTS(MAX_SLOTS), .SLOT_US(SLOT_US)) u_store (
    .clk_i,
    .wr_en_i, .wr_addr_i, .wr_kind_i,
    .kind_idx_i(kind_idx), .kind_o(kind),
    .cap_we_i(cap_we), .cap_idx_i(cap_idx), .cap_val_i(cap_val),
    .rd_addr_i, .rd_time_o
  );

  ow_seq #(
    .MAX_SLOTS(MAX_SLOTS), .SLOT_US(SLOT_US),
    .W1_LOW_US(W1_LOW_US), .W0_LOW_US(W0_LOW_US), .RD_LOW_US(RD_LOW_US),
    .RST_LOW_US(RST_LOW_US), .RST_WIN_US(RST_WIN_US), .PRES_MIN_US(PRES_MIN_US)
  ) u_seq (
    .clk_i, .rst_ni,
    .tick_i(tick), .rise_i(rise),
    .start_rst_i, .start_xfer_i, .count_i,
    .kind_i(kind), .kind_idx_o(kind_idx),
    .cap_we_o(cap_we), .cap_idx_o(cap_idx), .cap_val_o(cap_val),
    .clr_o(clr), .bus_oe_o, .done_o, .presence_o
  );

  assign rd_bit_o = (rd_time_o > RD_ONE_GT);
endmodule

// File: tb/ow_slot_engine_tb.sv
`timescale 1ns/1ps
module ow_slot_engine_tb;
  localparam int DIV  = 4;
  localparam int SLOT = 80;
  localparam int NV   = 12;
  // {kind[9:8], device hold in us[7:0]}
  localparam logic [9:0] VEC [NV] = '{
    {2'd1, 8'd0},  {2'd0, 8'd0},  {2'd2, 8'd0},  {2'd2, 8'd15},
    {2'd2, 8'd16}, {2'd2, 8'd40}, {2'd1, 8'd30}, {2'd0, 8'd75},
    {2'd2, 8'd80}, {2'd3, 8'd5},  {2'd0, 8'd20}, {2'd2, 8'd79}
  };

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, start_rst = 0, start_xfer = 0;
  logic [6:0] wr_addr = 0, rd_addr = 0;
  logic [1:0] wr_kind = 0;
  logic [7:0] count = 0;
  logic [6:0] rd_time;
  logic       rd_bit, done, presence, bus_oe, bus;

  int checks = 0, errors = 0, cyc = 0;
  int hold_arr [128];
  int slot_ctr = 0, dev_cnt = 0;
  logic oe_d = 0;

  always #2.5 clk = ~clk;

  assign bus = ~(bus_oe | (dev_cnt != 0));

  ow_slot_engine #(.CLK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_kind_i(wr_kind),
    .count_i(count), .start_rst_i(start_rst), .start_xfer_i(start_xfer),
    .rd_addr_i(rd_addr), .rd_time_o(rd_time), .rd_bit_o(rd_bit),
    .done_o(done), .presence_o(presence),
    .bus_oe_o(bus_oe), .bus_i(bus)
  );

  // device model: on each start of master low, stretch low to hold_arr[slot] us
  initial forever begin
    @(posedge clk);
    oe_d <= bus_oe;
    if (bus_oe && !oe_d) begin
      dev_cnt  <= (hold_arr[slot_ctr] > 0) ? hold_arr[slot_ctr] * DIV - 1 : 0;
      slot_ctr <= slot_ctr + 1;
    end else if (dev_cnt != 0) begin
      dev_cnt <= dev_cnt - 1;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, got %0d cycles exp < 190000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic wr_slot(input int a, input int k);
    @(negedge clk);
    wr_en = 1; wr_addr = 7'(a); wr_kind = 2'(k);
    @(negedge clk);
    wr_en = 0;
  endtask

  // n = clocks from the accepting edge to the first sample showing done
  task automatic run_op(input bit r, input bit x, input int inj,
                        output int n, output bit done_at_0);
    @(negedge clk);
    slot_ctr = 0;
    start_rst = r; start_xfer = x;
    @(negedge clk);
    start_rst = 0; start_xfer = 0;
    n = 0;
    done_at_0 = done;
    while (!done && n < 60000) begin
      if (n == inj) begin start_rst = 1; start_xfer = 1; end
      @(negedge clk);
      start_rst = 0; start_xfer = 0;
      n++;
    end
  endtask

  function automatic int exp_time(input int k, input int h);
    int low;
    low = (k == 0) ? 70 : 10;
    if (h >= SLOT) return SLOT;
    return (h > low) ? h : low;
  endfunction

  initial begin
    int n;
    bit d0;
    for (int i = 0; i < 128; i++) hold_arr[i] = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 done after reset", done, 0);
    chk("R6 presence after reset", presence, 0);
    chk("R2 bus released after reset", bus_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      wr_slot(i, int'(VEC[i][9:8]));
      hold_arr[i] = int'(VEC[i][7:0]);
    end
    count = 8'(NV);
    run_op(0, 1, -1, n, d0);
    chk("R8 done cleared by start", d0, 0);
    chk("R1 transfer length", n, NV * SLOT * DIV + 1);
    for (int i = 0; i < NV; i++) begin
      int e;
      e = exp_time(int'(VEC[i][9:8]), int'(VEC[i][7:0]));
      rd_addr = 7'(i);
      #1;
      chk((VEC[i][7:0] >= 8'd80) ? "R4 no-rise time" : "R3 slot time", int'(rd_time), e);
      chk("R3 read bit", int'(rd_bit), (e > 15) ? 1 : 0);
    end
    repeat (50) @(negedge clk);
    chk("R8 done holds", done, 1);

    // R5 R6: reset windows
    for (int i = 0; i < 128; i++) hold_arr[i] = 0;
    run_op(1, 0, -1, n, d0);
    chk("R5 reset length", n, 1000 * DIV + 1);
    chk("R6 no device", presence, 0);
    hold_arr[0] = 620;
    run_op(1, 0, -1, n, d0);
    chk("R6 presence at 620", presence, 1);
    hold_arr[0] = 599;
    run_op(1, 0, -1, n, d0);
    chk("R6 rise at 599 absent", presence, 0);
    hold_arr[0] = 600;
    run_op(1, 0, -1, n, d0);
    chk("R6 rise at 600 present", presence, 1);

    // R9: strobes while busy ignored
    hold_arr[0] = 0;
    wr_slot(0, 1); wr_slot(1, 0);
    count = 8'd2;
    run_op(0, 1, 100, n, d0);
    chk("R9 busy strobe ignored", n, 2 * SLOT * DIV + 1);
    rd_addr = 7'd1; #1;
    chk("R9 slot 1 unaffected", int'(rd_time), 70);

    // R9: both strobes in idle -> reset
    run_op(1, 1, -1, n, d0);
    chk("R9 reset priority", n, 1000 * DIV + 1);

    // R7: empty and over-long counts
    count = 8'd0;
    run_op(0, 1, -1, n, d0);
    chk("R7 zero count", n, 1);
    for (int i = 0; i < 128; i++) wr_slot(i, 0);
    count = 8'd200;
    run_op(0, 1, -1, n, d0);
    chk("R7 clamp to 128 slots", n, 128 * SLOT * DIV + 1);
    rd_addr = 7'd127; #1;
    chk("R7 last slot written", int'(rd_time), 70);
    rd_addr = 7'd0; #1;
    chk("R2 write-0 slot 0", int'(rd_time), 70);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule